// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps memory requests from the processor side onto the PCIe bus address space through one programmable outbound window. Configuration software writes five registers through a simple write port. Two 32-bit words form a 64-bit bus-side base. One 32-bit packed word holds bits 31:20 of both the window's first and last CPU address. Two 8-bit registers hold bits 39:32 of the first and last CPU address. The window therefore has 1 MiB granularity: the low 20 bits of the first address are zero and the low 20 bits of the last address are all ones.

Each request carries a 40-bit CPU address. One cycle later the block returns a registered response. The response says whether the address fell inside the window and, on a hit, gives the bus address: the bus base plus the offset of the request from the window's first CPU address.

A four-state controller guards the window:
- `ST_EMPTY`: the state after reset.
- `ST_CHECK`: entered on any write to a CPU-side window field.
- `ST_OPEN`: the reassembled limit is at or above the base.
- `ST_BAD`: the reassembled limit is below the base.

Transitions:
- `ST_EMPTY`, `ST_OPEN` and `ST_BAD` move to `ST_CHECK` on a window-field write.
- `ST_CHECK` stays in `ST_CHECK` while window-field writes keep arriving.
- When there is no such write, `ST_CHECK` resolves to `ST_OPEN` or `ST_BAD`.

Hits are produced only in `ST_OPEN`.

Top module: `ow_translator`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit` and `rsp_bus_addr` are 0, and no request hits until a CPU-side window field has been written and the window has been checked.
- R2: `cfg_sel` codes are 0 = bus base bits 31:0, 1 = bus base bits 63:32, 2 = packed CPU word, 3 = start high byte (`cfg_wdata[7:0]`), 4 = end high byte (`cfg_wdata[7:0]`). Writes with codes 5 to 7 change no register and no state.
- R3: The window base is {start high byte, packed word bits 15:4, 20 zero bits}.
- R4: The window limit is {end high byte, packed word bits 31:20, 20 one bits}.
- R5: A request hits when the window is open and base <= `req_addr` <= limit, with both bounds inclusive.
- R6: On a hit `rsp_bus_addr` = bus base + (`req_addr` - base), taken modulo 2^64.
- R7: `rsp_valid` equals `req_valid` of the previous cycle, and `rsp_hit`/`rsp_bus_addr` describe that request.
- R8: When `rsp_hit` is 0, `rsp_bus_addr` is 0.
- R9: A write with code 2, 3 or 4 puts the controller in `ST_CHECK` for the next cycle, where requests miss. The cycle after the last such write, the controller resolves to `ST_OPEN` or `ST_BAD`.
- R10: When the reassembled limit is below the base (`ST_BAD`), no request hits.
- R11: Writes to the bus base (codes 0 and 1) leave the controller state unchanged and apply to requests from the next cycle on.
- R12: A request in the same cycle as a register write is judged with the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code (see R2) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | CPU-side request address |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | Request fell inside the open window |
| rsp_bus_addr | output | 64 | Translated bus address, 0 on a miss |

## Verification
The assertions assume that reset is applied before the first request and that the select code on an idle write strobe is irrelevant. They also assume the window leaves `ST_OPEN` only through a CPU-side field write, so an open window always satisfies limit >= base. The stimulus is driven only between clock edges and stays within 40-bit addresses. It deliberately probes the exact base, the exact limit and the addresses one below and one above. It also reprograms the window into a reversed (limit below base) configuration and places requests in the same cycle as writes and in the check cycle that follows them.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam int CPU_AW  = 40;
    localparam int BUS_AW  = 64;
    localparam int REG_W   = 32;
    localparam int GRAN_W  = 20;
    localparam int SEL_W   = 3;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_CHECK = 2'd1,
        ST_OPEN  = 2'd2,
        ST_BAD   = 2'd3
    } win_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_BUS_LO   = 3'd0,
        SEL_BUS_HI   = 3'd1,
        SEL_CPU_PACK = 3'd2,
        SEL_CPU_SHI  = 3'd3,
        SEL_CPU_EHI  = 3'd4
    } reg_sel_e;

    localparam int SEL_COUNT = 5;

    typedef struct packed {
        logic [CPU_AW-1:0] base;
        logic [CPU_AW-1:0] limit;
    } cpu_win_t;

endpackage

// File: rtl/ow_regbank.sv
module ow_regbank
    import ow_pkg::*;
#(
    parameter int P_CPU_AW = CPU_AW,
    parameter int P_BUS_AW = BUS_AW,
    parameter int P_REG_W  = REG_W,
    parameter int P_GRAN_W = GRAN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [P_REG_W-1:0]    wr_data,
    output logic [P_BUS_AW-1:0]   bus_base,
    output cpu_win_t              win,
    output logic                  win_touch
);
    localparam int NWORDS   = P_BUS_AW / P_REG_W;
    localparam int MID_W    = P_REG_W - P_GRAN_W;
    localparam int HI_W     = P_CPU_AW - P_REG_W;
    localparam int BASE_LSB = P_GRAN_W - 16;

    logic [MID_W-1:0] base_mid_q;
    logic [MID_W-1:0] lim_mid_q;
    logic [HI_W-1:0]  start_hi_q;
    logic [HI_W-1:0]  end_hi_q;

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_bus_word
            logic [P_REG_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && wr_sel == SEL_W'(w)) begin
                    word_q <= wr_data;
                end
            end
            assign bus_base[w*P_REG_W +: P_REG_W] = word_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_mid_q <= '0;
            lim_mid_q  <= '0;
            start_hi_q <= '0;
            end_hi_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CPU_PACK) begin
                base_mid_q <= wr_data[BASE_LSB +: MID_W];
                lim_mid_q  <= wr_data[P_GRAN_W +: MID_W];
            end
            if (wr_sel == SEL_CPU_SHI) start_hi_q <= wr_data[HI_W-1:0];
            if (wr_sel == SEL_CPU_EHI) end_hi_q   <= wr_data[HI_W-1:0];
        end
    end

    always_comb begin
        win.base  = {start_hi_q, base_mid_q, {P_GRAN_W{1'b0}}};
        win.limit = {end_hi_q,   lim_mid_q,  {P_GRAN_W{1'b1}}};
        win_touch = wr_en && (wr_sel == SEL_CPU_PACK || wr_sel == SEL_CPU_SHI ||
                              wr_sel == SEL_CPU_EHI);
    end

    // R2: unused select codes leave every register untouched
    p_ignored_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel >= SEL_W'(SEL_COUNT)) |=>
            ($stable(bus_base) && $stable(win)));

    // R11: a bus-base write leaves the CPU-side window fields alone
    p_bus_write_keeps_win_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel < SEL_W'(NWORDS)) |=> $stable(win));

endmodule

// File: rtl/ow_window_fsm.sv
module ow_window_fsm
    import ow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     win_touch,
    input  cpu_win_t win,
    output logic     win_open
);
    win_state_e state_q;
    win_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (win_touch) state_d = ST_CHECK;
            ST_CHECK: begin
                if (win_touch)                  state_d = ST_CHECK;
                else if (win.limit >= win.base) state_d = ST_OPEN;
                else                            state_d = ST_BAD;
            end
            ST_OPEN:  if (win_touch) state_d = ST_CHECK;
            ST_BAD:   if (win_touch) state_d = ST_CHECK;
        endcase
    end

    always_comb begin
        win_open = 1'b0;
        unique case (state_q)
            ST_EMPTY: win_open = 1'b0;
            ST_CHECK: win_open = 1'b0;
            ST_OPEN:  win_open = 1'b1;
            ST_BAD:   win_open = 1'b0;
        endcase
    end

    // R9: a window-field write always lands in the check state
    p_touch_to_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_touch |=> (state_q == ST_CHECK));

    // R9: the check state resolves once writes stop
    p_check_resolves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !win_touch) |=>
            (state_q == ST_OPEN || state_q == ST_BAD));

    // R10: an open window is never reversed
    p_open_ordered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> (win.limit >= win.base));

endmodule

// File: rtl/ow_xlate.sv
module ow_xlate
    import ow_pkg::*;
#(
    parameter int P_CPU_AW = CPU_AW,
    parameter int P_BUS_AW = BUS_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [P_CPU_AW-1:0] req_addr,
    input  logic                win_open,
    input  cpu_win_t            win,
    input  logic [P_BUS_AW-1:0] bus_base,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [P_BUS_AW-1:0] rsp_bus_addr
);
    localparam int EXT_W = P_BUS_AW - P_CPU_AW;

    logic                above_base;
    logic                below_limit;
    logic                hit_d;
    logic [P_CPU_AW-1:0] offset;
    logic [P_BUS_AW-1:0] xlated;

    always_comb begin
        above_base  = req_addr >= win.base;
        below_limit = req_addr <= win.limit;
        hit_d       = req_valid && win_open && above_base && below_limit;
        offset      = req_addr - win.base;
        xlated      = bus_base + {{EXT_W{1'b0}}, offset};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_bus_addr <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_hit      <= hit_d;
            rsp_bus_addr <= hit_d ? xlated : '0;
        end
    end

    // R7: response follows the request by one cycle
    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: a miss carries a zero address
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_bus_addr == '0));

    // R10: a closed window never yields a hit
    p_closed_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !rsp_hit);

    // R5: a hit came from an address inside the window
    p_hit_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($past(req_addr) >= $past(win.base) &&
                     $past(req_addr) <= $past(win.limit)));

endmodule

// File: rtl/ow_translator.sv
module ow_translator
    import ow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [CPU_AW-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BUS_AW-1:0] rsp_bus_addr
);
    logic [BUS_AW-1:0] bus_base;
    cpu_win_t          win;
    logic              win_touch;
    logic              win_open;

    ow_regbank #(
        .P_CPU_AW (CPU_AW),
        .P_BUS_AW (BUS_AW),
        .P_REG_W  (REG_W),
        .P_GRAN_W (GRAN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .bus_base  (bus_base),
        .win       (win),
        .win_touch (win_touch)
    );

    ow_window_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_touch (win_touch),
        .win       (win),
        .win_open  (win_open)
    );

    ow_xlate #(
        .P_CPU_AW (CPU_AW),
        .P_BUS_AW (BUS_AW)
    ) u_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .win_open     (win_open),
        .win          (win),
        .bus_base     (bus_base),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_bus_addr (rsp_bus_addr)
    );

endmodule

// File: tb/ow_translator_test.sv
`timescale 1ns/1ps
module ow_translator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_bus_addr;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    ow_translator uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bus_addr(rsp_bus_addr)
    );

    // Behavioural reference model
    logic [63:0] m_bus;
    logic [31:0] m_pack;
    logic [7:0]  m_shi, m_ehi;
    int          m_st;       // 0 empty, 1 check, 2 open, 3 bad
    logic        e_v, e_h;
    logic [63:0] e_a;
    string       e_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        logic [39:0] lo, hi;
        logic        inwin;
        if (!rst_n) begin
            m_bus = '0; m_pack = '0; m_shi = '0; m_ehi = '0; m_st = 0;
            e_v = 1'b0; e_h = 1'b0; e_a = '0; e_tag = "R1";
        end else begin
            lo    = {m_shi, m_pack[15:4], 20'h00000};
            hi    = {m_ehi, m_pack[31:20], 20'hFFFFF};
            inwin = (m_st == 2) && req_valid && (req_addr >= lo) && (req_addr <= hi);
            e_v   = req_valid;
            e_h   = inwin;
            e_a   = inwin ? (m_bus + {24'h0, req_addr} - {24'h0, lo}) : 64'h0;
            e_tag = tag;
            if (cfg_wr_en && cfg_sel >= 3'd2 && cfg_sel <= 3'd4) m_st = 1;
            else if (m_st == 1) m_st = (hi >= lo) ? 2 : 3;
            if (cfg_wr_en) begin
                case (cfg_sel)
                    3'd0: m_bus[31:0]  = cfg_wdata;
                    3'd1: m_bus[63:32] = cfg_wdata;
                    3'd2: m_pack       = cfg_wdata;
                    3'd3: m_shi        = cfg_wdata[7:0];
                    3'd4: m_ehi        = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (rsp_valid !== e_v) begin
                fails++;
                $display("FAIL %s/R7 rsp_valid actual=%0b expected=%0b", e_tag, rsp_valid, e_v);
            end else if (rsp_hit !== e_h) begin
                fails++;
                $display("FAIL %s/R5 rsp_hit actual=%0b expected=%0b", e_tag, rsp_hit, e_h);
            end else if (rsp_bus_addr !== e_a) begin
                fails++;
                $display("FAIL %s/R6 rsp_bus_addr actual=%h expected=%h", e_tag, rsp_bus_addr, e_a);
            end
        end
    end

    task automatic step(input bit wen, input logic [2:0] sel, input logic [31:0] d,
                        input bit rv, input logic [39:0] a);
        @(negedge clk);
        cfg_wr_en = wen; cfg_sel = sel; cfg_wdata = d;
        req_valid = rv;  req_addr = a;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        step(1'b1, sel, d, 1'b0, '0);
    endtask

    task automatic rd(input logic [39:0] a);
        step(1'b0, 3'd0, '0, 1'b1, a);
    endtask

    task automatic idle();
        step(1'b0, 3'd0, '0, 1'b0, '0);
    endtask

    localparam logic [39:0] W_LO = 40'h01_8000_0000;
    localparam logic [39:0] W_HI = 40'h01_8FFF_FFFF;

    initial begin
        logic [31:0] lfsr = 32'hACE1_2357;
        // R1: reset state and empty window
        tag = "R1";
        repeat (3) step(1'b0, 3'd0, '0, 1'b1, W_LO);
        rst_n = 1'b1;
        rd(40'h0); rd(40'h00_000F_FFFF); rd(W_LO);
        // R11: bus base writes keep the empty state
        tag = "R11";
        wr(3'd0, 32'hC000_0000); wr(3'd1, 32'h0000_0012);
        rd(40'h0); rd(W_LO);
        // R3 / R4: program the window 0x01_8000_0000 .. 0x01_8FFF_FFFF
        tag = "R3";
        wr(3'd2, 32'h8FF0_8000); wr(3'd3, 32'h0000_0001);
        tag = "R4";
        wr(3'd4, 32'h0000_0001);
        tag = "R9";
        rd(W_LO);               // check cycle: miss
        rd(W_LO);               // open now
        // R5: inclusive bounds
        tag = "R5";
        rd(W_LO); rd(W_HI); rd(W_LO - 40'd1); rd(W_HI + 40'd1);
        rd(40'h01_8123_4567); rd(40'hFF_FFFF_FFFF);
        // R6: translation values
        tag = "R6";
        rd(40'h01_8000_0010); rd(40'h01_8ABC_DEF0);
        // R2: unused select codes
        tag = "R2";
        wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'h0000_0000); wr(3'd7, 32'h1234_5678);
        rd(W_LO); rd(W_HI);
        // R12: request during a write sees old values; R9 check cycle misses
        tag = "R12";
        step(1'b1, 3'd1, 32'h0000_0034, 1'b1, W_LO + 40'd5);
        rd(W_LO + 40'd5);
        step(1'b1, 3'd2, 32'h9FF0_9000, 1'b1, W_LO);
        tag = "R9";
        rd(40'h01_9000_0000);
        rd(40'h01_9000_0000); rd(W_LO);
        // R10: reversed window never hits
        tag = "R10";
        wr(3'd4, 32'h0000_0000);
        rd(40'h01_9000_0000); rd(40'h00_9FFF_FFFF); rd(40'h01_9FFF_FFFF);
        // R9: back-to-back touches stay in check
        tag = "R9";
        step(1'b1, 3'd4, 32'h0000_0001, 1'b1, 40'h01_9000_0000);
        step(1'b1, 3'd3, 32'h0000_0001, 1'b1, 40'h01_9000_0000);
        rd(40'h01_9000_0000); rd(40'h01_9000_0000);
        // R6: wrapping bus base
        tag = "R6";
        wr(3'd0, 32'hFFFF_FFF0); wr(3'd1, 32'hFFFF_FFFF);
        rd(40'h01_9000_0008); rd(40'h01_9000_0020); rd(40'h01_9FFF_FFFF);
        // R8 / R5: pseudo-random sweep around the window
        tag = "R8";
        for (int i = 0; i < 200; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            step(1'b0, 3'd0, '0, lfsr[0], 40'h01_8F00_0000 + {8'h0, 4'h0, lfsr[31:4]});
        end
        idle(); idle();
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule